// File: doc/BRIEF.md
# Burst Word-Count Event Tracker

This block follows transmit and receive bursts for a serial-peripheral controller. Each direction owns a word counter. Software writes a reload value, and one clock later that value becomes the counter. Every word moved in that direction then counts it down by one. Two moments of a burst raise a sticky event flag: the counter being loaded (start) and the counter stepping down to zero (finish). Software acknowledges each flag by writing a 1 to its bit.

The same status word also holds a coarse receive-queue fill code. It compares the receive occupancy against quarter steps of the queue depth. Watermark logic elsewhere uses this code. The serial shifter, the queue storage and interrupt routing sit outside this block. It sees them only as per-word strobes and an occupancy count.

Top module: `burst_wc_status`

## Requirements
- R1: A write to address 1 stores the transmit reload value. On the next clock edge the transmit counter (read at address 4) takes that value. If control bits 0 and 1 are both set, status bit 0 (transmit start) is set on the same edge.
- R2: A `txWordStb` pulse lowers the transmit counter by one, but only while control bit 1 is set and the counter is nonzero. At zero the counter holds until the next reload. With control bit 1 clear, a strobe leaves the counter unchanged.
- R3: When a transmit strobe takes the counter from 1 to 0, status bit 2 (transmit finish) is set on that edge, provided control bits 0 and 1 are both set.
- R4: The receive direction behaves the same way. Its reload is at address 2, its counter is read at address 4+1=5 and its strobe is `rxWordStb`. Control bits 2 and 3 are its enables. Receive start is status bit 1 and receive finish is status bit 3.
- R5: When either enable of a direction is clear, that direction's start and finish flags are not set. Its loads and countdown still take place as in R1, R2 and R4.
- R6: A write to address 3 clears each flag whose bit in the written data [3:0] is 1, effective on that edge. A bit written as 0 leaves its flag as it was.
- R7: If a flag is set and cleared in the same cycle, the flag ends up set.
- R8: Status bits [6:4] hold the fill code, with the same-cycle occupancy `rxFifoLevel` measured against depth D=16:
  - 0 when the level is below D/4;
  - 1 when the level is at least D/4;
  - 2 when it is at least D/2;
  - 3 when it is at least 3D/4;
  - 4 when it is at least D.
  Codes 5 to 7 never appear.
- R9: A word strobe in the cycle where a reload is being copied into the counter is ignored. A reload written while a burst is still counting restarts the burst at the new value.
- R10: In a burst of length one, start and finish are both set. Each must be cleared by its own bit.
- R11: After reset, the control register, both reload values, both counters and all four flags read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address for read and write: 0 control, 1 tx reload, 2 rx reload, 3 status, 4 tx count, 5 rx count |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data for `regAddr`, combinational |
| txWordStb | input | 1 | One transmit word moved |
| rxWordStb | input | 1 | One receive word moved |
| rxFifoLevel | input | 5 | Receive queue occupancy in words |

## Verification
A reload write lands in the counter, and raises the start flag, one edge after the write edge. A strobe changes the counter and the finish flag on its own edge. A flag clear takes effect on the write edge. The fill code follows `rxFifoLevel` in the same cycle. The bench drives inputs just after a falling edge. It advances a behavioural model on each rising edge and compares the read data at the next falling edge, so every result is sampled exactly one edge after the stimulus that caused it. Directed reads with literal expected values are placed on those same edges, for instance one read after a reload write to see the loaded count.

// File: rtl/burst_wc_pkg.sv
package burst_wc_pkg;

  localparam int REG_ADDR_W = 3;

  localparam logic [REG_ADDR_W-1:0] ADDR_CTRL      = 3'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_TX_RELOAD = 3'd1;
  localparam logic [REG_ADDR_W-1:0] ADDR_RX_RELOAD = 3'd2;
  localparam logic [REG_ADDR_W-1:0] ADDR_STATUS    = 3'd3;
  localparam logic [REG_ADDR_W-1:0] ADDR_TX_COUNT  = 3'd4;
  localparam logic [REG_ADDR_W-1:0] ADDR_RX_COUNT  = 3'd5;

  localparam int NUM_DIR = 2;
  localparam int DIR_TX  = 0;
  localparam int DIR_RX  = 1;

  // control bit 2*d = initiate enable, bit 2*d+1 = count enable
  localparam int CTRL_W = 2 * NUM_DIR;

  localparam int FLAG_W   = 2 * NUM_DIR;
  localparam int CODE_W   = 3;
  localparam int STATUS_W = FLAG_W + CODE_W;

  typedef enum logic [CODE_W-1:0] {
    FILL_EMPTY   = 3'd0,
    FILL_QUARTER = 3'd1,
    FILL_HALF    = 3'd2,
    FILL_3QUART  = 3'd3,
    FILL_FULL    = 3'd4
  } fillCode_t;

  typedef struct packed {
    logic               ctrlWr;
    logic [NUM_DIR-1:0] reloadWr;
    logic [NUM_DIR-1:0] clrStart;
    logic [NUM_DIR-1:0] clrFin;
  } wcStrobes_t;

endpackage

// File: rtl/burst_wc_channel.sv
module burst_wc_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reloadWr,
  input  logic [CNT_W-1:0] reloadVal,
  input  logic             wordStb,
  input  logic             initEn,
  input  logic             cntEn,
  input  logic             clrStart,
  input  logic             clrFin,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] reload,
  output logic             startFlag,
  output logic             finFlag
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic loadPend;
  logic flagEn;
  logic doDec;
  logic setStart;
  logic setFin;

  always_comb begin
    flagEn   = initEn & cntEn;
    doDec    = !loadPend && wordStb && cntEn && (count != '0);
    setStart = loadPend && flagEn;
    setFin   = doDec && (count == CNT_ONE) && flagEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reload   <= '0;
      loadPend <= 1'b0;
    end else begin
      loadPend <= reloadWr;
      if (reloadWr) reload <= reloadVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (loadPend) begin
      count <= reload;
    end else if (doDec) begin
      count <= count - CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startFlag <= 1'b0;
      finFlag   <= 1'b0;
    end else begin
      startFlag <= (startFlag & ~clrStart) | setStart;
      finFlag   <= (finFlag & ~clrFin) | setFin;
    end
  end

  // R1: pending reload is copied on the following edge
  p_load_r1: assert property (@(posedge clk) disable iff (!rstN)
    loadPend |=> (count == $past(reload)));

  // R1, R7: start flag set on load even against a clear
  p_start_r1: assert property (@(posedge clk) disable iff (!rstN)
    (loadPend && initEn && cntEn) |=> startFlag);

  // R2: counter parks at zero without a reload
  p_hold_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (count == '0 && !loadPend) |=> (count == '0));

  // R2: one step down per accepted strobe
  p_dec_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!loadPend && wordStb && cntEn && count != '0) |=> (count == $past(count) - CNT_ONE));

  // R3: finish flag on reaching zero
  p_fin_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!loadPend && wordStb && cntEn && initEn && count == CNT_ONE) |=> finFlag);

  // R5: no new flags while gated
  p_gate_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!(initEn && cntEn) && !startFlag && !finFlag) |=> (!startFlag && !finFlag));

  // R9: strobe ignored during a load cycle
  p_load_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    (loadPend && wordStb) |=> (count == $past(reload)));

endmodule

// File: rtl/burst_wc_datapath.sv
module burst_wc_datapath
  import burst_wc_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int FIFO_DEPTH = 16,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  wcStrobes_t                      strb,
  input  logic [CNT_W-1:0]                wrVal,
  input  logic [NUM_DIR-1:0]              wordStb,
  input  logic [NUM_DIR-1:0]              initEn,
  input  logic [NUM_DIR-1:0]              cntEn,
  input  logic [LVL_W-1:0]                fifoLevel,
  output logic [NUM_DIR-1:0][CNT_W-1:0]   counts,
  output logic [NUM_DIR-1:0][CNT_W-1:0]   reloads,
  output logic [NUM_DIR-1:0]              startFlags,
  output logic [NUM_DIR-1:0]              finFlags,
  output fillCode_t                       fillCode
);

  localparam int SCALED_W = LVL_W + 2;
  localparam logic [SCALED_W-1:0] TH_QUARTER = SCALED_W'(FIFO_DEPTH);
  localparam logic [SCALED_W-1:0] TH_HALF    = SCALED_W'(2 * FIFO_DEPTH);
  localparam logic [SCALED_W-1:0] TH_3QUART  = SCALED_W'(3 * FIFO_DEPTH);
  localparam logic [LVL_W-1:0]    TH_FULL    = LVL_W'(FIFO_DEPTH);

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    burst_wc_channel #(
      .CNT_W(CNT_W)
    ) i_chan (
      .clk      (clk),
      .rstN     (rstN),
      .reloadWr (strb.reloadWr[d]),
      .reloadVal(wrVal),
      .wordStb  (wordStb[d]),
      .initEn   (initEn[d]),
      .cntEn    (cntEn[d]),
      .clrStart (strb.clrStart[d]),
      .clrFin   (strb.clrFin[d]),
      .count    (counts[d]),
      .reload   (reloads[d]),
      .startFlag(startFlags[d]),
      .finFlag  (finFlags[d])
    );
  end

  // quarter-step fill code: highest threshold reached wins
  logic [SCALED_W-1:0] levelX4;

  always_comb begin
    levelX4 = SCALED_W'(fifoLevel) << 2;
    if (fifoLevel >= TH_FULL)          fillCode = FILL_FULL;
    else if (levelX4 >= TH_3QUART)     fillCode = FILL_3QUART;
    else if (levelX4 >= TH_HALF)       fillCode = FILL_HALF;
    else if (levelX4 >= TH_QUARTER)    fillCode = FILL_QUARTER;
    else                               fillCode = FILL_EMPTY;
  end

  // R8: only the five defined codes
  p_code_range_r8: assert property (@(posedge clk) disable iff (!rstN)
    fillCode <= FILL_FULL);

  // R8: an empty queue never reports a fill step
  p_empty_r8: assert property (@(posedge clk) disable iff (!rstN)
    (fifoLevel == '0) |-> (fillCode == FILL_EMPTY));

endmodule

// File: rtl/burst_wc_ctrl.sv
module burst_wc_ctrl
  import burst_wc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           regWrEn,
  input  logic [REG_ADDR_W-1:0]          regAddr,
  input  logic [DATA_W-1:0]              regWrData,
  input  logic [NUM_DIR-1:0][CNT_W-1:0]  counts,
  input  logic [NUM_DIR-1:0][CNT_W-1:0]  reloads,
  input  logic [NUM_DIR-1:0]             startFlags,
  input  logic [NUM_DIR-1:0]             finFlags,
  input  fillCode_t                      fillCode,
  output wcStrobes_t                     strb,
  output logic [NUM_DIR-1:0]             initEn,
  output logic [NUM_DIR-1:0]             cntEn,
  output logic [DATA_W-1:0]              regRdData
);

  logic [CTRL_W-1:0]   ctrlReg;
  logic [STATUS_W-1:0] statusWord;

  always_comb begin
    strb                   = '0;
    strb.ctrlWr            = regWrEn && (regAddr == ADDR_CTRL);
    strb.reloadWr[DIR_TX]  = regWrEn && (regAddr == ADDR_TX_RELOAD);
    strb.reloadWr[DIR_RX]  = regWrEn && (regAddr == ADDR_RX_RELOAD);
    if (regWrEn && regAddr == ADDR_STATUS) begin
      strb.clrStart = regWrData[NUM_DIR-1:0];
      strb.clrFin   = regWrData[FLAG_W-1:NUM_DIR];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            ctrlReg <= '0;
    else if (strb.ctrlWr) ctrlReg <= regWrData[CTRL_W-1:0];
  end

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_en
    assign initEn[d] = ctrlReg[2*d];
    assign cntEn[d]  = ctrlReg[2*d+1];
  end

  always_comb begin
    statusWord = {fillCode, finFlags, startFlags};
    unique case (regAddr)
      ADDR_CTRL:      regRdData = DATA_W'(ctrlReg);
      ADDR_TX_RELOAD: regRdData = DATA_W'(reloads[DIR_TX]);
      ADDR_RX_RELOAD: regRdData = DATA_W'(reloads[DIR_RX]);
      ADDR_STATUS:    regRdData = DATA_W'(statusWord);
      ADDR_TX_COUNT:  regRdData = DATA_W'(counts[DIR_TX]);
      ADDR_RX_COUNT:  regRdData = DATA_W'(counts[DIR_RX]);
      default:        regRdData = '0;
    endcase
  end

  // R6: a write reaches at most one register
  p_one_target_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.ctrlWr, strb.reloadWr, |{strb.clrStart, strb.clrFin}}));

  // R6: clears only come from a status write
  p_clr_src_r6: assert property (@(posedge clk) disable iff (!rstN)
    (|{strb.clrStart, strb.clrFin}) |-> (regWrEn && regAddr == ADDR_STATUS));

endmodule

// File: rtl/burst_wc_status.sv
module burst_wc_status
  import burst_wc_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int CNT_W      = 16,
  parameter int FIFO_DEPTH = 16,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0]     regWrData,
  output logic [DATA_W-1:0]     regRdData,
  input  logic                  txWordStb,
  input  logic                  rxWordStb,
  input  logic [LVL_W-1:0]      rxFifoLevel
);

  wcStrobes_t                    strb;
  logic [NUM_DIR-1:0]            initEn;
  logic [NUM_DIR-1:0]            cntEn;
  logic [NUM_DIR-1:0][CNT_W-1:0] counts;
  logic [NUM_DIR-1:0][CNT_W-1:0] reloads;
  logic [NUM_DIR-1:0]            startFlags;
  logic [NUM_DIR-1:0]            finFlags;
  fillCode_t                     fillCode;
  logic [NUM_DIR-1:0]            wordStb;

  always_comb begin
    wordStb         = '0;
    wordStb[DIR_TX] = txWordStb;
    wordStb[DIR_RX] = rxWordStb;
  end

  burst_wc_ctrl #(
    .DATA_W(DATA_W),
    .CNT_W (CNT_W)
  ) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .counts    (counts),
    .reloads   (reloads),
    .startFlags(startFlags),
    .finFlags  (finFlags),
    .fillCode  (fillCode),
    .strb      (strb),
    .initEn    (initEn),
    .cntEn     (cntEn),
    .regRdData (regRdData)
  );

  burst_wc_datapath #(
    .CNT_W     (CNT_W),
    .FIFO_DEPTH(FIFO_DEPTH),
    .LVL_W     (LVL_W)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrVal     (regWrData[CNT_W-1:0]),
    .wordStb   (wordStb),
    .initEn    (initEn),
    .cntEn     (cntEn),
    .fifoLevel (rxFifoLevel),
    .counts    (counts),
    .reloads   (reloads),
    .startFlags(startFlags),
    .finFlags  (finFlags),
    .fillCode  (fillCode)
  );

endmodule

// File: tb/test_burst_wc_status.sv
`timescale 1ns/100ps
module test_burst_wc_status;

  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [15:0] regWrData = 16'd0;
  logic [15:0] regRdData;
  logic        txWordStb = 1'b0;
  logic        rxWordStb = 1'b0;
  logic [4:0]  rxFifoLevel = 5'd0;

  int nChecks = 0;
  int nFails  = 0;
  bit running = 1'b0;

  always #2.5 clk = ~clk;

  burst_wc_status i_burst_wc_status (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .txWordStb  (txWordStb),
    .rxWordStb  (rxWordStb),
    .rxFifoLevel(rxFifoLevel)
  );

  // ---------------- behavioural reference ----------------
  int mCtrl;
  int mRel[2];
  int mCnt[2];
  bit mPend[2];
  bit mFlag[4];   // 0 tx start, 1 rx start, 2 tx finish, 3 rx finish

  function automatic int fillOf(int lvl);
    if (lvl >= DEPTH)              return 4;
    if (lvl * 100 >= 75 * DEPTH)   return 3;
    if (lvl * 100 >= 50 * DEPTH)   return 2;
    if (lvl * 100 >= 25 * DEPTH)   return 1;
    return 0;
  endfunction

  function automatic int modelRead(int a);
    case (a)
      0: return mCtrl;
      1: return mRel[0];
      2: return mRel[1];
      3: return (fillOf(int'(rxFifoLevel)) << 4) | (int'(mFlag[3]) << 3) |
                (int'(mFlag[2]) << 2) | (int'(mFlag[1]) << 1) | int'(mFlag[0]);
      4: return mCnt[0];
      5: return mCnt[1];
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCtrl = 0;
      for (int d = 0; d < 2; d++) begin
        mRel[d] = 0; mCnt[d] = 0; mPend[d] = 1'b0;
      end
      for (int f = 0; f < 4; f++) mFlag[f] = 1'b0;
    end else begin
      bit setS[2];
      bit setF[2];
      bit stb[2];
      stb[0] = txWordStb;
      stb[1] = rxWordStb;
      for (int d = 0; d < 2; d++) begin
        bool_block: begin
          bit gate;
          bit cen;
          gate = mCtrl[2*d] && mCtrl[2*d+1];
          cen  = mCtrl[2*d+1];
          setS[d] = 1'b0;
          setF[d] = 1'b0;
          if (mPend[d]) begin
            mCnt[d] = mRel[d];
            setS[d] = gate;
          end else if (stb[d] && cen && mCnt[d] > 0) begin
            mCnt[d] = mCnt[d] - 1;
            if (mCnt[d] == 0) setF[d] = gate;
          end
          mPend[d] = regWrEn && (int'(regAddr) == d + 1);
          if (mPend[d]) mRel[d] = int'(regWrData);
        end
      end
      if (regWrEn && regAddr == 3'd3)
        for (int f = 0; f < 4; f++) if (regWrData[f]) mFlag[f] = 1'b0;
      for (int d = 0; d < 2; d++) begin
        if (setS[d]) mFlag[d] = 1'b1;
        if (setF[d]) mFlag[d+2] = 1'b1;
      end
      if (regWrEn && regAddr == 3'd0) mCtrl = int'(regWrData[3:0]);
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (running) begin
      nChecks++;
      if (int'(regRdData) != modelRead(int'(regAddr))) begin
        nFails++;
        $display("FAIL model R1,R2,R3,R4,R5,R6,R7,R8,R9,R10 addr %0d: actual %0h expected %0h",
                 regAddr, regRdData, modelRead(int'(regAddr)));
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic wr(input int a, input int v);
    regWrEn = 1'b1; regAddr = 3'(a); regWrData = 16'(v);
    tick();
    regWrEn = 1'b0;
  endtask

  task automatic strobe(input bit tx, input bit rx);
    txWordStb = tx; rxWordStb = rx;
    tick();
    txWordStb = 1'b0; rxWordStb = 1'b0;
  endtask

  task automatic expectRd(input int a, input int exp, input string tag);
    regAddr = 3'(a);
    @(negedge clk);
    nChecks++;
    if (int'(regRdData) != exp) begin
      nFails++;
      $display("FAIL %s addr %0d: actual %0h expected %0h", tag, a, regRdData, exp);
    end
    #1;
  endtask

  task automatic expectFill(input int lvl, input int code);
    rxFifoLevel = 5'(lvl);
    expectRd(3, code << 4, "R8");
  endtask

  // watchdog
  initial begin
    #(5 * 20000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    running = 1'b1;

    // R11: reset values
    expectRd(3, 0, "R11");
    expectRd(4, 0, "R11");
    expectRd(5, 0, "R11");
    expectRd(0, 0, "R11");
    expectRd(1, 0, "R11");

    // R1 / R2 / R3: transmit burst of three
    wr(0, 4'hF);
    wr(1, 3);
    expectRd(4, 3, "R1");
    expectRd(3, 8'h01, "R1");
    strobe(1, 0);
    strobe(1, 0);
    expectRd(4, 1, "R2");
    expectRd(3, 8'h01, "R3");
    strobe(1, 0);
    expectRd(3, 8'h05, "R3");
    expectRd(4, 0, "R2");
    strobe(1, 0);
    expectRd(4, 0, "R2");

    // R6: clear one flag at a time
    wr(3, 4'h4);
    expectRd(3, 8'h01, "R6");
    wr(3, 4'h1);
    expectRd(3, 8'h00, "R6");

    // R4: receive burst of two
    wr(2, 2);
    expectRd(5, 2, "R4");
    expectRd(3, 8'h02, "R4");
    strobe(0, 1);
    strobe(0, 1);
    expectRd(3, 8'h0A, "R4");
    expectRd(5, 0, "R4");
    wr(3, 4'hF);
    expectRd(3, 0, "R6");

    // R5: initiate enable off, burst still runs without flags
    wr(0, 4'hE);
    wr(1, 2);
    expectRd(4, 2, "R5");
    expectRd(3, 0, "R5");
    strobe(1, 0);
    strobe(1, 0);
    expectRd(4, 0, "R5");
    expectRd(3, 0, "R5");
    // R2 / R5: count enable off, strobes ignored
    wr(0, 4'hD);
    wr(1, 2);
    expectRd(4, 2, "R5");
    strobe(1, 0);
    expectRd(4, 2, "R2");
    expectRd(3, 0, "R5");

    // R7: clear lands on the load edge, set wins
    wr(0, 4'hF);
    wr(1, 1);
    wr(3, 4'h1);
    expectRd(3, 8'h01, "R7");
    // R10: length-one burst, separate clears
    strobe(1, 0);
    expectRd(3, 8'h05, "R10");
    wr(3, 4'h1);
    expectRd(3, 8'h04, "R10");
    wr(3, 4'h4);
    expectRd(3, 8'h00, "R10");

    // R9: strobe during load ignored, restart mid-burst
    wr(1, 3);
    strobe(1, 0);
    expectRd(4, 3, "R9");
    strobe(1, 0);
    expectRd(4, 2, "R9");
    wr(1, 5);
    expectRd(4, 5, "R9");
    wr(3, 4'hF);
    expectRd(3, 0, "R9");

    // R8: fill code thresholds
    expectFill(0, 0);
    expectFill(3, 0);
    expectFill(4, 1);
    expectFill(7, 1);
    expectFill(8, 2);
    expectFill(11, 2);
    expectFill(12, 3);
    expectFill(15, 3);
    expectFill(16, 4);
    expectFill(31, 4);
    rxFifoLevel = 5'd0;
    tick();

    running = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule